// File: doc/BRIEF.md
# Virtual Address Translation Unit

This block turns a 32-bit virtual address into a physical address for one of three access kinds: instruction fetch, data read or data write. Each request is checked against a small, fully associative table of page entries. Every entry holds an address-space tag, a shared flag, a page-size code, two protection bits and a dirty bit. Two fixed high address windows are never translated. Privileged code may use both of them. User code may only use a small slice of the top window. A global translation-enable input turns the whole low space into a flat 29-bit map.

The result is registered. One cycle after a request, the unit presents either a physical address or a fault code. Each kind of fault has its own code: miss, multiple hit, protection violation, first write to a clean page, and address error. On every fault except a multiple hit, the page-number field of the fault-address register is loaded from the offending address. The address-space tag in that register is left alone. That tag is also the tag used for matching, and software sets it through a separate write strobe. Page entries are loaded one at a time through a simple indexed write port.

Top module: `xlt_unit`

## Requirements
- R1: In privileged mode, an address from 0x80000000 to 0xBFFFFFFF is not translated. The physical address is the virtual address with bits 31:29 cleared, and no fault is raised.
- R2: In privileged mode, an address at or above 0xE0000000 is not translated and is returned unchanged, with no fault.
- R3: In user mode, an access to either untranslated window is an address error, unless the address lies in 0xE0000000–0xE3FFFFFF. The code is 0x0E0 for fetches and reads and 0x100 for writes. Inside 0xE0000000–0xE3FFFFFF the address is returned unchanged.
- R4: When translation is disabled (`xlat_en`=0), any address outside the two untranslated windows maps to the address ANDed with 0x1FFFFFFF, with no fault and no permission checks.
- R5: The address-space tag is compared unless `sv_mode` is 1 and the access is privileged. An entry whose shared flag is set matches any tag.
- R6: The size code selects the page size: 0 → 1 KB, 1 → 4 KB, 2 → 64 KB, 3 → 1 MB. An entry matches when it is valid and the address lies inside the page at (page number << 10) aligned down to that size. The physical address is (frame number << 10) aligned to the page size, ORed with the page-offset bits of the virtual address.
- R7: If more than one entry matches, the code is 0x140 and the fault-address register is unchanged.
- R8: A miss gives code 0x040 for fetches and reads and 0x060 for writes.
- R9: A user access to an entry whose protection bit 1 is 0 gives code 0x0A0 for fetches and reads and 0x0C0 for writes. Otherwise, a write to an entry whose protection bit 0 is 0 gives code 0x0C0.
- R10: A write that passes the permission checks to an entry whose dirty bit is 0 gives code 0x080.
- R11: On any fault other than a multiple hit, `pteh[31:10]` is loaded with `req_addr[31:10]`. `pteh[7:0]` (the address-space tag) changes only through `asid_we`, and `pteh[9:8]` reads 0.
- R12: `rsp_valid` is high exactly one cycle after `req_valid`. `rsp_code` is 0 when `rsp_fault` is 0. After reset, `rsp_valid` is 0, `pteh` is 0 and all entries are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write |
| priv | input | 1 | 1 = privileged access |
| xlat_en | input | 1 | Translation enable |
| sv_mode | input | 1 | Privileged accesses ignore the address-space tag when 1 |
| asid_we | input | 1 | Load the address-space tag in `pteh` |
| asid_wdata | input | 8 | New address-space tag |
| ent_we | input | 1 | Page entry write strobe |
| ent_idx | input | 2 | Entry index (log2 of depth) |
| ent_valid | input | 1 | Entry valid bit |
| ent_shared | input | 1 | Entry shared flag |
| ent_dirty | input | 1 | Entry dirty bit |
| ent_prot | input | 2 | Bit 1 user access allowed, bit 0 write allowed |
| ent_size | input | 2 | Page size code |
| ent_asid | input | 8 | Entry address-space tag |
| ent_vpn | input | 22 | Virtual page number (address bits 31:10) |
| ent_ppn | input | 19 | Physical frame number (address bits 28:10) |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 1 | Result is a fault |
| rsp_code | output | 12 | Fault code, 0 when no fault |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| pteh | output | 32 | Fault page number [31:10], address-space tag [7:0] |

## Verification
The bench uses four page sizes with offsets placed right at the page edges. A unit that masks the wrong bit count either misses a neighbouring kilobyte that should hit, or leaks frame bits into the offset. It checks that a tag mismatch misses, and that a shared entry or the privileged tag-bypass hits; a wrong tag rule turns those into hits or misses. It forces two overlapping entries and confirms that code 0x140 appears and that the fault-address register is not touched. It covers the protection and dirty priority order, since a reordered check reports the wrong one of 0x0C0 and 0x080. It also probes the user store-queue slice at its lower bound and one byte past its upper bound, and reads the fault-address register after each fault.

// File: rtl/xlt_pkg.sv
// Package: shared types, fault codes and the page-size helper for the
// translation unit. Assumes 32-bit virtual and 29-bit physical addresses.
package xlt_pkg;
    localparam int VA_W   = 32;
    localparam int VPN_W  = 22;
    localparam int PPN_W  = 19;
    localparam int ASID_W = 8;
    localparam int CODE_W = 12;

    localparam logic [1:0] KIND_FETCH = 2'd0;
    localparam logic [1:0] KIND_READ  = 2'd1;
    localparam logic [1:0] KIND_WRITE = 2'd2;

    localparam logic [CODE_W-1:0] C_RD_MISS  = 12'h040;
    localparam logic [CODE_W-1:0] C_WR_MISS  = 12'h060;
    localparam logic [CODE_W-1:0] C_CLEAN_WR = 12'h080;
    localparam logic [CODE_W-1:0] C_RD_PROT  = 12'h0A0;
    localparam logic [CODE_W-1:0] C_WR_PROT  = 12'h0C0;
    localparam logic [CODE_W-1:0] C_RD_ADDR  = 12'h0E0;
    localparam logic [CODE_W-1:0] C_WR_ADDR  = 12'h100;
    localparam logic [CODE_W-1:0] C_MULTI    = 12'h140;

    typedef struct packed {
        logic              valid;
        logic              shared;
        logic              dirty;
        logic [1:0]        prot;
        logic [1:0]        size;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
    } tlb_entry_t;

    // Offset mask for a size code: 1 KB, 4 KB, 64 KB, 1 MB.
    function automatic logic [VA_W-1:0] page_off_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_03FF;
            2'd1:    return 32'h0000_0FFF;
            2'd2:    return 32'h0000_FFFF;
            default: return 32'h000F_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/xlt_store.sv
// Entry store: DEPTH page entries written through one indexed port.
// Assumes the caller keeps the index within range. Reset clears all entries.
module xlt_store
    import xlt_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  tlb_entry_t       wdata,
    output tlb_entry_t       entries [DEPTH]
);
    tlb_entry_t mem [DEPTH];

    // Reset clears every entry; a write replaces the indexed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign entries = mem;
endmodule

// File: rtl/xlt_match.sv
// Match array: compares one address with every entry in parallel. It
// flags a hit and a multiple hit and ORs together the matching entries.
// The selected entry is only meaningful when exactly one entry hits.
module xlt_match
    import xlt_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic [VA_W-1:0]   addr,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              use_asid,
    input  tlb_entry_t        entries [DEPTH],
    output logic              hit,
    output logic              multi,
    output tlb_entry_t        sel
);
    logic [DEPTH-1:0] hit_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic [VA_W-1:0] msk;
        logic [VA_W-1:0] base;
        logic            tag_ok;
        assign msk    = page_off_mask(entries[g].size);
        assign base   = {entries[g].vpn, 10'b0};
        assign tag_ok = entries[g].shared || !use_asid ||
                        (entries[g].asid == cur_asid);
        assign hit_vec[g] = entries[g].valid && tag_ok &&
                            ((addr & ~msk) == (base & ~msk));
    end

    // Count the hits and OR the matching entries together.
    always_comb begin
        int unsigned cnt;
        cnt = 0;
        sel = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i]) begin
                cnt = cnt + 1;
                sel = sel | entries[i];
            end
        end
        hit   = (cnt != 0);
        multi = (cnt > 1);
    end
endmodule

// File: rtl/xlt_classify.sv
// Classifier: decides the region, the checks to apply and the outcome of
// one access. Fixed windows are checked first, then the enable, then the
// match result. Protection is checked before the dirty bit.
module xlt_classify
    import xlt_pkg::*;
(
    input  logic [VA_W-1:0]   addr,
    input  logic [1:0]        kind,
    input  logic              priv,
    input  logic              xlat_en,
    input  logic              hit,
    input  logic              multi,
    input  tlb_entry_t        sel,
    output logic              fault,
    output logic [CODE_W-1:0] code,
    output logic [VA_W-1:0]   paddr
);
    logic is_wr, in_p12, in_p4, in_sq;
    logic [VA_W-1:0] msk;

    assign is_wr  = (kind == KIND_WRITE);
    assign in_p12 = (addr[31:30] == 2'b10);
    assign in_p4  = (addr[31:29] == 3'b111);
    assign in_sq  = (addr[31:26] == 6'b111000);
    assign msk    = page_off_mask(sel.size);

    // Pick the outcome of the access in priority order.
    always_comb begin
        fault = 1'b0;
        code  = '0;
        paddr = '0;
        if (in_p12 || in_p4) begin
            if (!priv && !in_sq) begin
                fault = 1'b1;
                code  = is_wr ? C_WR_ADDR : C_RD_ADDR;
            end else begin
                paddr = in_p12 ? {3'b000, addr[28:0]} : addr;
            end
        end else if (!xlat_en) begin
            paddr = {3'b000, addr[28:0]};
        end else if (multi) begin
            fault = 1'b1;
            code  = C_MULTI;
        end else if (!hit) begin
            fault = 1'b1;
            code  = is_wr ? C_WR_MISS : C_RD_MISS;
        end else if (!priv && !sel.prot[1]) begin
            fault = 1'b1;
            code  = is_wr ? C_WR_PROT : C_RD_PROT;
        end else if (is_wr && !sel.prot[0]) begin
            fault = 1'b1;
            code  = C_WR_PROT;
        end else if (is_wr && !sel.dirty) begin
            fault = 1'b1;
            code  = C_CLEAN_WR;
        end else begin
            paddr = ({3'b000, sel.ppn, 10'b0} & ~msk) | (addr & msk);
        end
    end
endmodule

// File: rtl/xlt_unit.sv
// Translation unit top: entry store, match array and classifier, with a
// registered result and the fault-address register. Assumes requests come
// at most one per cycle; the result follows one cycle later.
module xlt_unit
    import xlt_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    input  logic [1:0]        req_kind,
    input  logic              priv,
    input  logic              xlat_en,
    input  logic              sv_mode,
    input  logic              asid_we,
    input  logic [7:0]        asid_wdata,
    input  logic              ent_we,
    input  logic [IDX_W-1:0]  ent_idx,
    input  logic              ent_valid,
    input  logic              ent_shared,
    input  logic              ent_dirty,
    input  logic [1:0]        ent_prot,
    input  logic [1:0]        ent_size,
    input  logic [7:0]        ent_asid,
    input  logic [21:0]       ent_vpn,
    input  logic [18:0]       ent_ppn,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [11:0]       rsp_code,
    output logic [31:0]       rsp_paddr,
    output logic [31:0]       pteh
);
    tlb_entry_t        wentry;
    tlb_entry_t        entries [DEPTH];
    tlb_entry_t        sel;
    logic              hit, multi, c_fault;
    logic [CODE_W-1:0] c_code;
    logic [VA_W-1:0]   c_paddr;
    logic [VPN_W-1:0]  fault_vpn;
    logic [ASID_W-1:0] cur_asid;

    assign wentry = '{valid: ent_valid, shared: ent_shared, dirty: ent_dirty,
                      prot: ent_prot, size: ent_size, asid: ent_asid,
                      vpn: ent_vpn, ppn: ent_ppn};

    xlt_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .we(ent_we), .idx(ent_idx),
        .wdata(wentry), .entries(entries)
    );

    xlt_match #(.DEPTH(DEPTH)) u_match (
        .addr(req_addr), .cur_asid(cur_asid),
        .use_asid(!(sv_mode && priv)), .entries(entries),
        .hit(hit), .multi(multi), .sel(sel)
    );

    xlt_classify u_cls (
        .addr(req_addr), .kind(req_kind), .priv(priv), .xlat_en(xlat_en),
        .hit(hit), .multi(multi), .sel(sel),
        .fault(c_fault), .code(c_code), .paddr(c_paddr)
    );

    // Register the result of the current request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_code  <= '0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_fault <= req_valid && c_fault;
            rsp_code  <= req_valid ? c_code : '0;
            rsp_paddr <= req_valid ? c_paddr : '0;
        end
    end

    // Fault page number on non-multiple faults; tag only by explicit write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_vpn <= '0;
            cur_asid  <= '0;
        end else begin
            if (req_valid && c_fault && c_code != C_MULTI)
                fault_vpn <= req_addr[31:10];
            if (asid_we)
                cur_asid <= asid_wdata;
        end
    end

    assign pteh = {fault_vpn, 2'b00, cur_asid};
endmodule

// File: rtl/xlt_unit_chk.sv
// Checker for xlt_unit: port-level timing and region properties, bound
// to every instance of the top module.
module xlt_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        priv,
    input logic        xlat_en,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [11:0] rsp_code,
    input logic [31:0] rsp_paddr,
    input logic [31:0] pteh
);
    a_r12_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r12_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_fault |-> rsp_code == 12'h000);
    a_r1_p12_strip: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && priv && req_addr[31:30] == 2'b10) |=>
        (!rsp_fault && rsp_paddr == {3'b000, $past(req_addr[28:0])}));
    a_r3_user_window: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !priv && req_addr[31:30] == 2'b10) |=>
        (rsp_fault && (rsp_code == 12'h0E0 || rsp_code == 12'h100)));
    a_r4_flat_map: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !xlat_en && !req_addr[31]) |=>
        (!rsp_fault && rsp_paddr[31:29] == 3'b000));
    a_r11_vpn_only_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pteh[31:10]) |-> (rsp_valid && rsp_fault && rsp_code != 12'h140));
    a_r7_multi_keeps_pteh: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 12'h140) |-> $stable(pteh));
endmodule

bind xlt_unit xlt_unit_chk u_chk (.*);

// File: tb/tb_xlt_unit.sv
// Directed bench for xlt_unit: one task per scenario, each checking itself.
module tb_xlt_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [1:0]  req_kind;
    logic        priv, xlat_en, sv_mode;
    logic        asid_we;
    logic [7:0]  asid_wdata;
    logic        ent_we;
    logic [1:0]  ent_idx;
    logic        ent_valid, ent_shared, ent_dirty;
    logic [1:0]  ent_prot, ent_size;
    logic [7:0]  ent_asid;
    logic [21:0] ent_vpn;
    logic [18:0] ent_ppn;
    logic        rsp_valid, rsp_fault;
    logic [11:0] rsp_code;
    logic [31:0] rsp_paddr, pteh;

    int total = 0;
    int bad   = 0;
    localparam logic [1:0] KF = 2'd0, KR = 2'd1, KW = 2'd2;

    always #5 clk = ~clk;

    xlt_unit dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [1:0] i, input logic [21:0] vpn, input logic [7:0] asid,
                        input logic [18:0] ppn, input logic [1:0] sz, input logic [1:0] pr,
                        input logic sh, input logic d);
        @(negedge clk);
        ent_we = 1; ent_idx = i; ent_valid = 1; ent_shared = sh; ent_dirty = d;
        ent_prot = pr; ent_size = sz; ent_asid = asid; ent_vpn = vpn; ent_ppn = ppn;
        @(negedge clk);
        ent_we = 0;
    endtask

    task automatic set_asid(input logic [7:0] a);
        @(negedge clk);
        asid_we = 1; asid_wdata = a;
        @(negedge clk);
        asid_we = 0;
    endtask

    task automatic access(input string req, input logic [31:0] a, input logic [1:0] k,
                          input logic p, input logic ef, input logic [11:0] ec,
                          input logic [31:0] ep);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_kind = k; priv = p;
        @(negedge clk);
        req_valid = 0;
        check({req, " valid"}, {31'b0, rsp_valid}, 32'd1);
        check({req, " fault"}, {31'b0, rsp_fault}, {31'b0, ef});
        check({req, " code"}, {20'b0, rsp_code}, {20'b0, ec});
        if (!ef) check({req, " paddr"}, rsp_paddr, ep);
    endtask

    task automatic t_reset;
        check("R12 reset valid", {31'b0, rsp_valid}, 32'd0);
        check("R12 reset pteh", pteh, 32'd0);
        xlat_en = 1;
        access("R12 empty table miss", 32'h0040_0000, KR, 1, 1, 12'h040, 0);
    endtask

    task automatic t_bypass;
        access("R1 p1 priv", 32'hA123_4567, KR, 1, 0, 0, 32'h0123_4567);
        access("R1 p0 priv", 32'h8000_0010, KW, 1, 0, 0, 32'h0000_0010);
        access("R2 p4 priv", 32'hF000_0010, KR, 1, 0, 0, 32'hF000_0010);
        access("R3 user read", 32'h8000_0000, KR, 0, 1, 12'h0E0, 0);
        check("R11 pteh after addr err", pteh, 32'h8000_0000);
        access("R3 user write", 32'hBFFF_FFFC, KW, 0, 1, 12'h100, 0);
        access("R3 user fetch", 32'hF000_0000, KF, 0, 1, 12'h0E0, 0);
        access("R3 user sq low", 32'hE000_0000, KW, 0, 0, 0, 32'hE000_0000);
        access("R3 user sq high", 32'hE3FF_FFFF, KR, 0, 0, 0, 32'hE3FF_FFFF);
        access("R3 user past sq", 32'hE400_0000, KR, 0, 1, 12'h0E0, 0);
    endtask

    task automatic t_flat;
        xlat_en = 0;
        access("R4 flat low", 32'h4000_1234, KW, 0, 0, 0, 32'h0000_1234);
        access("R4 flat C region", 32'hC800_0000, KR, 0, 0, 0, 32'h0800_0000);
        xlat_en = 1;
    endtask

    task automatic t_asid;
        // e0: 4KB page 0x00400000 -> 0x00800000, tag 0x11, full rights, dirty
        load(0, 22'h001000, 8'h11, 19'h02000, 2'd1, 2'b11, 0, 1);
        set_asid(8'h11);
        access("R5 tag match", 32'h0040_0ABC, KR, 0, 0, 0, 32'h0080_0ABC);
        set_asid(8'h22);
        access("R8 read miss", 32'h0040_0ABC, KR, 0, 1, 12'h040, 0);
        check("R11 pteh after miss", pteh, 32'h0040_0822);
        access("R8 write miss", 32'h0040_0ABC, KW, 1, 1, 12'h060, 0);
        sv_mode = 1;
        access("R5 sv privileged", 32'h0040_0FFF, KR, 1, 0, 0, 32'h0080_0FFF);
        access("R5 sv user still tagged", 32'h0040_0000, KF, 0, 1, 12'h040, 0);
        sv_mode = 0;
        set_asid(8'h11);
    endtask

    task automatic t_sizes;
        // e1: 64KB shared user-readonly clean 0x01230000 -> 0x03450000
        load(1, 22'h0048C0, 8'h77, 19'h0D140, 2'd2, 2'b10, 1, 0);
        // e2: 1MB 0x05000000 -> 0x0A000000 full rights clean
        load(2, 22'h014000, 8'h11, 19'h28000, 2'd3, 2'b11, 0, 0);
        // e3: 1KB 0x00600000 -> 0x00700400 privileged only
        load(3, 22'h001800, 8'h11, 19'h01C01, 2'd0, 2'b00, 0, 1);
        access("R6 64KB shared", 32'h0123_ABCD, KR, 0, 0, 0, 32'h0345_ABCD);
        access("R6 1MB top", 32'h050F_FFFF, KR, 1, 0, 0, 32'h0A0F_FFFF);
        access("R6 1MB past end", 32'h0510_0000, KR, 1, 1, 12'h040, 0);
        access("R6 1KB", 32'h0060_0123, KR, 1, 0, 0, 32'h0070_0523);
        access("R6 1KB next kb", 32'h0060_0423, KR, 1, 1, 12'h040, 0);
    endtask

    task automatic t_prot;
        access("R9 user read priv-only", 32'h0060_0123, KR, 0, 1, 12'h0A0, 0);
        access("R9 user fetch priv-only", 32'h0060_0000, KF, 0, 1, 12'h0A0, 0);
        access("R9 user write priv-only", 32'h0060_0123, KW, 0, 1, 12'h0C0, 0);
        access("R9 priv write readonly", 32'h0060_0123, KW, 1, 1, 12'h0C0, 0);
        access("R9 write readonly clean", 32'h0123_0000, KW, 0, 1, 12'h0C0, 0);
        access("R10 write clean", 32'h0500_0040, KW, 0, 1, 12'h080, 0);
        check("R11 pteh keeps tag", pteh, 32'h0500_0011);
        access("R10 write dirty ok", 32'h0040_0004, KW, 0, 0, 0, 32'h0080_0004);
    endtask

    task automatic t_multi;
        // e3 now overlaps e0 as a shared 4KB page
        load(3, 22'h001000, 8'h00, 19'h00001, 2'd1, 2'b11, 1, 1);
        access("R11 set pteh", 32'h0777_7000, KR, 1, 1, 12'h040, 0);
        access("R7 multiple hit", 32'h0040_0ABC, KR, 1, 1, 12'h140, 0);
        check("R7 pteh unchanged", pteh, 32'h0777_7011);
    endtask

    initial begin
        rst_n = 0; req_valid = 0; req_addr = 0; req_kind = 0; priv = 1;
        xlat_en = 1; sv_mode = 0; asid_we = 0; asid_wdata = 0; ent_we = 0;
        ent_idx = 0; ent_valid = 0; ent_shared = 0; ent_dirty = 0; ent_prot = 0;
        ent_size = 0; ent_asid = 0; ent_vpn = 0; ent_ppn = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_flat();
        t_asid();
        t_sizes();
        t_prot();
        t_multi();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule